// File: doc/BRIEF.md
# Unsigned Fixed-Point to Floating-Point Converter

This block turns an unsigned fixed-point integer into an IEEE-754 binary value. The operand is 32 or 64 bits wide. A 6-bit scale code sets how many of its low bits lie below the binary point. One shared datapath finds the leading one, aligns the operand, rounds it and packs the result as half, single or double precision. The rounding mode is chosen for each operation.

The converted element goes into the low bits of a 128-bit result. The bits above the element either come from the previous destination value (merge) or are cleared. Each exception condition (inexact, underflow, overflow) either sets a sticky status flag or raises a one-cycle trap request, depending on its own trap-enable bit. Encodings that are not allowed raise an illegal indication and produce no result.

Top module: `ufx2fp_cvt`

## Requirements
- R1: With `src_wide`=0 only `src_val[31:0]` is converted and the upper 32 bits have no effect on the result. With `src_wide`=1 all 64 bits are converted. The operand is always treated as unsigned.
- R2: `fmt_code` selects the element format: 2'b00 single (32-bit element), 2'b01 double (64-bit element), 2'b11 half (16-bit element).
- R3: The encoding is illegal when `fmt_code`=2'b10, when `fmt_code`=2'b11 with `half_ok`=0, or when `src_wide`=0 with `scale_code[5]`=0. In that case, one cycle after the request, `illegal`=1 and `out_valid`=0. `result`, `xflags` and `trap_req` are left unchanged or idle.
- R4: The number of fraction bits is 64 minus the unsigned `scale_code`, so a code of 0 gives 64. The converted value is the operand divided by 2 to that power.
- R5: `rnd_mode` encodes 2'b00 nearest-even, 2'b01 toward +infinity, 2'b10 toward -infinity and 2'b11 toward zero. Because the input is never negative, toward -infinity rounds the same way as toward zero.
- R6: A zero operand gives +0 and raises no exception.
- R7: Whenever nonzero bits are discarded by rounding, the inexact condition (flag bit 0) is raised.
- R8: A half result whose rounded value exceeds 65504 raises overflow (bit 2) and inexact. The result is 0x7C00 (+infinity) under nearest-even or toward +infinity, and 0x7BFF under the other two modes.
- R9: A half value below 2^-14 is rounded on the subnormal grid of 2^-24. Underflow (bit 1) is raised when such a value is tiny before rounding and inexact. A value under half of 2^-24 gives +0 under nearest-even and 0x0001 under toward +infinity.
- R10: With `merge_en`=1, bits of `result` above the element equal `prev_dst`. With `merge_en`=0 they are zero.
- R11: For each raised condition, if `trap_en` has the matching bit (0 inexact, 1 underflow, 2 overflow), `trap_req` pulses and that flag is not set. Otherwise the bit is ORed into `xflags`, which clears only on reset.
- R12: `result`, `out_valid`, `xflags`, `trap_req` and `illegal` appear on the clock edge that captures `in_valid`. After reset all of them are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Conversion request for this cycle |
| src_val | input | 64 | Fixed-point operand |
| src_wide | input | 1 | 0: 32-bit operand, 1: 64-bit operand |
| fmt_code | input | 2 | Element format code |
| scale_code | input | 6 | Encoded scale; fraction bits = 64 - code |
| rnd_mode | input | 2 | Rounding mode |
| merge_en | input | 1 | Keep upper destination bits |
| prev_dst | input | 128 | Previous destination value |
| half_ok | input | 1 | Half precision permitted |
| trap_en | input | 3 | Trap enables {overflow, underflow, inexact} |
| out_valid | output | 1 | Result written this cycle |
| result | output | 128 | Converted and merged destination |
| xflags | output | 3 | Sticky flags {overflow, underflow, inexact} |
| illegal | output | 1 | Rejected encoding |
| trap_req | output | 1 | Trap request pulse |

## Verification
All five outputs come from a single register stage, so every result for a request is due on the first rising edge after `in_valid` is raised. Each scenario task drives its inputs on a falling edge, holds them through one rising edge, drops `in_valid` on the next falling edge and samples there, half a period after the result lands. The latency scenario also samples one cycle later to confirm that `out_valid` and `trap_req` fall back. The illegal scenario checks that the previous result and flags stay unchanged in that same sampling slot.

// File: rtl/ufx_pkg.sv
// Package: shared codes and types for the fixed-point to float converter.
// Assumes flag bit order {overflow, underflow, inexact} across all modules.
package ufx_pkg;

    typedef enum logic [1:0] {
        FMT_SP  = 2'b00,
        FMT_DP  = 2'b01,
        FMT_BAD = 2'b10,
        FMT_HP  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        RM_NE = 2'b00,
        RM_UP = 2'b01,
        RM_DN = 2'b10,
        RM_ZR = 2'b11
    } rmode_e;

    localparam int NFLAG = 3;

    typedef struct packed {
        logic of;
        logic uf;
        logic nx;
    } xflags_t;

endpackage

// File: rtl/ufx_lzd.sv
// Leading-one detector: returns the index of the highest set bit of vec.
// Assumes the caller ignores pos when zero is high.
module ufx_lzd #(
    parameter int W  = 64,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos,
    output logic          zero
);

    // Scan upward so the highest set bit wins.
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = PW'(i);
        end
        zero = ~|vec;
    end

endmodule

// File: rtl/ufx_round_pack.sv
// Align, round and pack one unsigned fixed-point magnitude into the selected
// float format. Combinational. Assumes fbits is in 1..SRC_W and that lead is
// the leading-one index of mag. Subnormals arise only for half precision.
module ufx_round_pack
    import ufx_pkg::*;
#(
    parameter int SRC_W = 64,
    parameter int EW    = 64,
    parameter int PW    = $clog2(SRC_W)
) (
    input  logic [SRC_W-1:0] mag,
    input  logic [PW-1:0]    lead,
    input  logic             is_zero,
    input  logic [PW:0]      fbits,
    input  fmt_e             fmt,
    input  rmode_e           rmode,
    output logic [EW-1:0]    elem,
    output xflags_t          xf
);

    localparam int XW   = 2 * SRC_W;
    localparam int SW   = $clog2(XW);
    localparam int SIGW = 55;
    localparam int PKW  = EW + 2;

    int              man_w;
    int              bias;
    int              emin;
    int              e_unb;
    int              e_eff;
    logic            tiny;
    logic [SW-1:0]   sh;
    logic [XW-1:0]   ext;
    logic [XW-1:0]   low_mask;
    logic [XW-1:0]   rem;
    logic [SIGW-1:0] sig;
    logic [SIGW-1:0] sig_r;
    logic            gbit;
    logic            sbit;
    logic            inc;
    logic [PKW-1:0]  packed_v;
    logic            ovf;

    // Format constants: mantissa width and exponent bias.
    always_comb begin
        case (fmt)
            FMT_HP:  begin man_w = 10; bias = 15;   end
            FMT_DP:  begin man_w = 52; bias = 1023; end
            default: begin man_w = 23; bias = 127;  end
        endcase
        emin = 1 - bias;
    end

    // Alignment: clamp the exponent at emin and extract guard and sticky bits.
    always_comb begin
        e_unb    = int'(lead) - int'(fbits);
        tiny     = (e_unb < emin);
        e_eff    = tiny ? emin : e_unb;
        sh       = SW'(e_eff - man_w + int'(fbits) + SRC_W);
        ext      = {mag, {SRC_W{1'b0}}};
        low_mask = ~({XW{1'b1}} << sh);
        rem      = ext & low_mask;
        sig      = SIGW'(ext >> sh);
        gbit     = rem[sh - SW'(1)];
        sbit     = |(rem & (low_mask >> 1));
    end

    // Rounding increment for a non-negative value.
    always_comb begin
        case (rmode)
            RM_NE:   inc = gbit & (sbit | sig[0]);
            RM_UP:   inc = gbit | sbit;
            default: inc = 1'b0;
        endcase
        sig_r = sig + SIGW'(inc);
    end

    // Pack: the carry from the significand flows into the exponent field.
    always_comb begin
        packed_v = (PKW'(e_eff + bias - 1) << man_w) + PKW'(sig_r);
        ovf      = (fmt == FMT_HP) && (packed_v >= PKW'(16'h7C00));
    end

    // Element assembly and exception conditions.
    always_comb begin
        elem = '0;
        xf   = '0;
        if (!is_zero) begin
            case (fmt)
                FMT_HP:  elem = EW'(packed_v[15:0]);
                FMT_DP:  elem = packed_v[EW-1:0];
                default: elem = EW'(packed_v[31:0]);
            endcase
            if (ovf) begin
                elem = (rmode == RM_NE || rmode == RM_UP) ? EW'(16'h7C00)
                                                          : EW'(16'h7BFF);
            end
            xf.of = ovf;
            xf.nx = gbit | sbit | ovf;
            xf.uf = tiny & (gbit | sbit);
        end
    end

endmodule

// File: rtl/ufx_excp.sv
// Exception routing: each raised condition either sets its sticky flag or,
// when its trap-enable bit is set, produces a one-cycle trap request.
// Assumes fire is high only for accepted, legal conversions.
module ufx_excp
    import ufx_pkg::*;
#(
    parameter int NF = NFLAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [NF-1:0] xf,
    input  logic [NF-1:0] trap_en,
    output logic [NF-1:0] flags,
    output logic          trap_req
);

    // Sticky flag accumulation and trap pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags    <= '0;
            trap_req <= 1'b0;
        end else begin
            flags    <= flags | (fire ? (xf & ~trap_en) : '0);
            trap_req <= fire & (|(xf & trap_en));
        end
    end

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & $past(flags)) == $past(flags)); // R11

    AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(fire)); // R11

endmodule

// File: rtl/ufx2fp_cvt.sv
// Top: unsigned fixed-point to float converter with one register stage.
// Decodes the encoding, finds the leading one, rounds and packs, merges the
// element into the 128-bit destination and routes exceptions.
// Assumes inputs are stable around the rising edge that samples in_valid.
module ufx2fp_cvt
    import ufx_pkg::*;
#(
    parameter int SRC_W = 64,
    parameter int DST_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SRC_W-1:0]  src_val,
    input  logic              src_wide,
    input  logic [1:0]        fmt_code,
    input  logic [5:0]        scale_code,
    input  logic [1:0]        rnd_mode,
    input  logic              merge_en,
    input  logic [DST_W-1:0]  prev_dst,
    input  logic              half_ok,
    input  logic [2:0]        trap_en,
    output logic              out_valid,
    output logic [DST_W-1:0]  result,
    output logic [2:0]        xflags,
    output logic              illegal,
    output logic              trap_req
);

    localparam int PW    = $clog2(SRC_W);
    localparam int HALFW = SRC_W / 2;
    localparam int EW    = 64;

    fmt_e              fmt;
    rmode_e            rmode;
    logic [PW:0]       fbits;
    logic [SRC_W-1:0]  mag;
    logic              bad;
    logic              fire;
    logic [PW-1:0]     lead;
    logic              is_zero;
    logic [EW-1:0]     elem;
    xflags_t           rp_xf;
    logic [DST_W-1:0]  nxt;

    // Decode controls and reject illegal encodings.
    always_comb begin
        fmt   = fmt_e'(fmt_code);
        rmode = rmode_e'(rnd_mode);
        fbits = (PW+1)'(SRC_W) - (PW+1)'(scale_code);
        mag   = src_wide ? src_val : {{HALFW{1'b0}}, src_val[HALFW-1:0]};
        bad   = (fmt == FMT_BAD) || (fmt == FMT_HP && !half_ok)
                || (!src_wide && !scale_code[5]);
        fire  = in_valid && !bad;
    end

    ufx_lzd #(.W(SRC_W), .PW(PW)) u_lzd (
        .vec  (mag),
        .pos  (lead),
        .zero (is_zero)
    );

    ufx_round_pack #(.SRC_W(SRC_W), .EW(EW), .PW(PW)) u_rp (
        .mag     (mag),
        .lead    (lead),
        .is_zero (is_zero),
        .fbits   (fbits),
        .fmt     (fmt),
        .rmode   (rmode),
        .elem    (elem),
        .xf      (rp_xf)
    );

    ufx_excp #(.NF(NFLAG)) u_excp (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .xf       (rp_xf),
        .trap_en  (trap_en),
        .flags    (xflags),
        .trap_req (trap_req)
    );

    // Merge the element into either the old destination or zeros.
    always_comb begin
        nxt = merge_en ? prev_dst : '0;
        case (fmt)
            FMT_HP:  nxt[15:0] = elem[15:0];
            FMT_DP:  nxt[63:0] = elem;
            default: nxt[31:0] = elem[31:0];
        endcase
    end

    // Output register stage; result holds unless a legal request fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= fire;
            illegal   <= in_valid && bad;
            if (fire) result <= nxt;
        end
    end

    AST_ILLEGAL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !out_valid); // R3

    AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bad) |=> ($stable(xflags) && $stable(result) && !trap_req)); // R3

    AST_MERGE_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && merge_en) |=> (result[DST_W-1:64] == $past(prev_dst[DST_W-1:64]))); // R10

    AST_ZERO_FILL_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !merge_en) |=> (result[DST_W-1:64] == '0)); // R10

    AST_OVERFLOW_HALF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && fmt != FMT_HP) |-> !rp_xf.of); // R8

    AST_UNDERFLOW_HALF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && fmt != FMT_HP) |-> !rp_xf.uf); // R9

    AST_ZERO_NO_EXCEPTION: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mag == '0) |=> ($stable(xflags) && !trap_req)); // R6

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R12

endmodule

// File: tb/ufx2fp_cvt_test.sv
// Directed bench: one task per scenario, each checking its own results.
module ufx2fp_cvt_test;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [63:0]  src_val;
    logic         src_wide;
    logic [1:0]   fmt_code;
    logic [5:0]   scale_code;
    logic [1:0]   rnd_mode;
    logic         merge_en;
    logic [127:0] prev_dst;
    logic         half_ok;
    logic [2:0]   trap_en;
    logic         out_valid;
    logic [127:0] result;
    logic [2:0]   xflags;
    logic         illegal;
    logic         trap_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [127:0] PREV = {64'hA5A5_A5A5_A5A5_A5A5, 64'h0123_4567_89AB_CDEF};

    ufx2fp_cvt uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_val(src_val),
        .src_wide(src_wide), .fmt_code(fmt_code), .scale_code(scale_code),
        .rnd_mode(rnd_mode), .merge_en(merge_en), .prev_dst(prev_dst),
        .half_ok(half_ok), .trap_en(trap_en), .out_valid(out_valid),
        .result(result), .xflags(xflags), .illegal(illegal), .trap_req(trap_req)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; src_val = '0; src_wide = 1'b1;
        fmt_code = 2'b00; scale_code = 6'd63; rnd_mode = 2'b00; merge_en = 1'b0;
        prev_dst = PREV; half_ok = 1'b1; trap_en = 3'b000;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Issue one request on a falling edge; sample at the next falling edge.
    task automatic conv(input logic [63:0] v, input logic wide, input logic [1:0] f,
                        input logic [5:0] sc, input logic [1:0] rm, input logic mg);
        @(negedge clk);
        src_val = v; src_wide = wide; fmt_code = f; scale_code = sc;
        rnd_mode = rm; merge_en = mg; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Convert, then check element, flags and valid.
    task automatic conv_chk(input string req, input logic [63:0] v, input logic wide,
                            input logic [1:0] f, input logic [5:0] sc, input logic [1:0] rm,
                            input logic [127:0] exp_res, input logic [2:0] exp_fl);
        conv(v, wide, f, sc, rm, 1'b0);
        chk(req, "result", result, exp_res);
        chk(req, "flags", {125'b0, xflags}, {125'b0, exp_fl});
        chk(req, "valid", {127'b0, out_valid}, 128'd1);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R12", "reset valid", {127'b0, out_valid}, 128'd0);
        chk("R12", "reset result", result, 128'd0);
        chk("R12", "reset flags", {125'b0, xflags}, 128'd0);
        chk("R12", "reset illegal", {127'b0, illegal}, 128'd0);
        chk("R12", "reset trap", {127'b0, trap_req}, 128'd0);
    endtask

    task automatic t_formats();
        do_reset();
        // R1: upper half ignored, 6 with 1 fraction bit = 3.0 single
        conv_chk("R1", 64'hDEAD_BEEF_0000_0006, 1'b0, 2'b00, 6'd63, 2'b00, 128'h4040_0000, 3'b000);
        // R2: 3.0 half and double
        conv_chk("R2", 64'd6, 1'b1, 2'b11, 6'd63, 2'b00, 128'h4200, 3'b000);
        conv_chk("R2", 64'd6, 1'b1, 2'b01, 6'd63, 2'b00, 128'h4008_0000_0000_0000, 3'b000);
        // R4: scale code 0 means 64 fraction bits; top bit alone is 0.5
        conv_chk("R4", 64'h8000_0000_0000_0000, 1'b1, 2'b01, 6'd0, 2'b00,
                 128'h3FE0_0000_0000_0000, 3'b000);
        conv_chk("R4", 64'd3, 1'b1, 2'b01, 6'd63, 2'b00, 128'h3FF8_0000_0000_0000, 3'b000);
    endtask

    task automatic t_rounding();
        do_reset();
        // R5: (2^24+1)/2^32 is a tie in single precision
        conv_chk("R5", 64'h0100_0001, 1'b0, 2'b00, 6'd32, 2'b00, 128'h3B80_0000, 3'b001);
        conv_chk("R5", 64'h0100_0001, 1'b0, 2'b00, 6'd32, 2'b01, 128'h3B80_0001, 3'b001);
        conv_chk("R5", 64'h0100_0001, 1'b0, 2'b00, 6'd32, 2'b10, 128'h3B80_0000, 3'b001);
        conv_chk("R5", 64'h0100_0001, 1'b0, 2'b00, 6'd32, 2'b11, 128'h3B80_0000, 3'b001);
        // R5: tie toward even goes up here
        conv_chk("R5", 64'h0100_0003, 1'b0, 2'b00, 6'd32, 2'b00, 128'h3B80_0002, 3'b001);
        do_reset();
        // R7: all-ones 64-bit, 64 fraction bits: rounds up to 1.0 or truncates
        conv_chk("R7", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'b01, 6'd0, 2'b00,
                 128'h3FF0_0000_0000_0000, 3'b001);
        conv_chk("R7", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'b01, 6'd0, 2'b11,
                 128'h3FEF_FFFF_FFFF_FFFF, 3'b001);
        conv_chk("R7", 64'h1234_5678_FFFF_FFFF, 1'b0, 2'b00, 6'd32, 2'b00,
                 128'h3F80_0000, 3'b001);
    endtask

    task automatic t_zero();
        do_reset();
        trap_en = 3'b111;
        conv_chk("R6", 64'd0, 1'b1, 2'b01, 6'd0, 2'b01, 128'd0, 3'b000);
        chk("R6", "no trap", {127'b0, trap_req}, 128'd0);
        conv_chk("R6", 64'hFFFF_FFFF_0000_0000, 1'b0, 2'b11, 6'd40, 2'b01, 128'd0, 3'b000);
        chk("R6", "no trap 32", {127'b0, trap_req}, 128'd0);
    endtask

    task automatic t_half_overflow();
        do_reset();
        conv_chk("R8", 64'd131008, 1'b1, 2'b11, 6'd63, 2'b00, 128'h7BFF, 3'b000);
        do_reset();
        conv_chk("R8", 64'd140000, 1'b1, 2'b11, 6'd63, 2'b00, 128'h7C00, 3'b101);
        conv_chk("R8", 64'd140000, 1'b1, 2'b11, 6'd63, 2'b01, 128'h7C00, 3'b101);
        conv_chk("R8", 64'd140000, 1'b1, 2'b11, 6'd63, 2'b10, 128'h7BFF, 3'b101);
        conv_chk("R8", 64'd140000, 1'b1, 2'b11, 6'd63, 2'b11, 128'h7BFF, 3'b101);
        do_reset();
        // 65520: nearest-even overflows, toward zero stays finite
        conv_chk("R8", 64'd131040, 1'b1, 2'b11, 6'd63, 2'b11, 128'h7BFF, 3'b001);
        conv_chk("R8", 64'd131040, 1'b1, 2'b11, 6'd63, 2'b00, 128'h7C00, 3'b101);
    endtask

    task automatic t_half_subnormal();
        do_reset();
        conv_chk("R9", 64'h1 << 40, 1'b1, 2'b11, 6'd0, 2'b00, 128'h0001, 3'b000);
        conv_chk("R9", 64'h1 << 49, 1'b1, 2'b11, 6'd0, 2'b00, 128'h0200, 3'b000);
        conv_chk("R9", 64'h1 << 50, 1'b1, 2'b11, 6'd0, 2'b00, 128'h0400, 3'b000);
        conv_chk("R9", 64'h1 << 39, 1'b1, 2'b11, 6'd0, 2'b00, 128'h0000, 3'b011);
        do_reset();
        conv_chk("R9", 64'h1 << 39, 1'b1, 2'b11, 6'd0, 2'b01, 128'h0001, 3'b011);
        conv_chk("R9", (64'h1 << 39) + 64'd1, 1'b1, 2'b11, 6'd0, 2'b00, 128'h0001, 3'b011);
        conv_chk("R9", (64'h1 << 50) - 64'd1, 1'b1, 2'b11, 6'd0, 2'b00, 128'h0400, 3'b011);
    endtask

    task automatic t_illegal();
        do_reset();
        conv_chk("R3", 64'd6, 1'b1, 2'b00, 6'd63, 2'b00, 128'h4040_0000, 3'b000);
        conv(64'd140000, 1'b1, 2'b10, 6'd63, 2'b00, 1'b0);
        chk("R3", "fmt10 illegal", {127'b0, illegal}, 128'd1);
        chk("R3", "fmt10 valid", {127'b0, out_valid}, 128'd0);
        chk("R3", "fmt10 result kept", result, 128'h4040_0000);
        half_ok = 1'b0;
        conv(64'd140000, 1'b1, 2'b11, 6'd63, 2'b00, 1'b0);
        chk("R3", "half off illegal", {127'b0, illegal}, 128'd1);
        chk("R3", "half off flags", {125'b0, xflags}, 128'd0);
        half_ok = 1'b1;
        conv(64'd3, 1'b0, 2'b01, 6'd31, 2'b00, 1'b0);
        chk("R3", "narrow scale illegal", {127'b0, illegal}, 128'd1);
        chk("R3", "narrow scale valid", {127'b0, out_valid}, 128'd0);
        chk("R3", "narrow scale result kept", result, 128'h4040_0000);
        conv(64'd6, 1'b0, 2'b11, 6'd32, 2'b00, 1'b0);
        chk("R3", "legal half clears illegal", {127'b0, illegal}, 128'd0);
        chk("R3", "legal half valid", {127'b0, out_valid}, 128'd1);
    endtask

    task automatic t_merge();
        do_reset();
        conv(64'd6, 1'b0, 2'b00, 6'd63, 2'b00, 1'b1);
        chk("R10", "single merged", result, {PREV[127:32], 32'h4040_0000});
        conv(64'd6, 1'b0, 2'b11, 6'd63, 2'b00, 1'b1);
        chk("R10", "half merged", result, {PREV[127:16], 16'h4200});
        conv(64'd3, 1'b1, 2'b01, 6'd63, 2'b00, 1'b1);
        chk("R10", "double merged", result, {PREV[127:64], 64'h3FF8_0000_0000_0000});
        conv(64'd6, 1'b0, 2'b11, 6'd63, 2'b00, 1'b0);
        chk("R10", "half zero filled", result, 128'h4200);
    endtask

    task automatic t_traps();
        do_reset();
        trap_en = 3'b001;
        conv_chk("R11", 64'h0100_0001, 1'b0, 2'b00, 6'd32, 2'b00, 128'h3B80_0000, 3'b000);
        chk("R11", "inexact trapped", {127'b0, trap_req}, 128'd1);
        trap_en = 3'b000;
        conv_chk("R11", 64'h0100_0001, 1'b0, 2'b00, 6'd32, 2'b00, 128'h3B80_0000, 3'b001);
        chk("R11", "inexact flagged", {127'b0, trap_req}, 128'd0);
        trap_en = 3'b100;
        conv_chk("R11", 64'd140000, 1'b1, 2'b11, 6'd63, 2'b00, 128'h7C00, 3'b001);
        chk("R11", "overflow trapped", {127'b0, trap_req}, 128'd1);
        trap_en = 3'b000;
        conv_chk("R11", 64'd6, 1'b1, 2'b00, 6'd63, 2'b00, 128'h4040_0000, 3'b001);
        chk("R11", "exact no trap", {127'b0, trap_req}, 128'd0);
    endtask

    task automatic t_latency();
        do_reset();
        trap_en = 3'b001;
        @(negedge clk);
        src_val = 64'h0100_0001; src_wide = 1'b0; fmt_code = 2'b00;
        scale_code = 6'd32; rnd_mode = 2'b00; merge_en = 1'b0; in_valid = 1'b1;
        chk("R12", "not valid before edge", {127'b0, out_valid}, 128'd0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12", "valid after one edge", {127'b0, out_valid}, 128'd1);
        chk("R12", "trap after one edge", {127'b0, trap_req}, 128'd1);
        @(negedge clk);
        chk("R12", "valid drops", {127'b0, out_valid}, 128'd0);
        chk("R12", "trap drops", {127'b0, trap_req}, 128'd0);
        chk("R12", "result held", result, 128'h3B80_0000);
        trap_en = 3'b000;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; src_val = '0; src_wide = 1'b1;
        fmt_code = 2'b00; scale_code = 6'd63; rnd_mode = 2'b00; merge_en = 1'b0;
        prev_dst = PREV; half_ok = 1'b1; trap_en = 3'b000;
        t_reset_state();
        t_formats();
        t_rounding();
        t_zero();
        t_half_overflow();
        t_half_subnormal();
        t_illegal();
        t_merge();
        t_traps();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule